// File: doc/BRIEF.md
# Register-Driven JTAG Vector Shifter

This block is a JTAG master shift engine behind a small window of 32-bit registers, the kind a host reaches through a configuration-space access path. For each transaction the host writes a bit count and a TMS vector, then writes a TDI vector to the shared data register. That write starts the engine. It runs up to 32 TCK cycles on the JTAG pins, taking one TMS bit and one TDI bit per cycle, least significant bit first. It stores the TDO bit sampled in each cycle into a result word, and the host reads that word back from the same data register.

The host owns all TAP state tracking. It splits long scans into chunks of 32 bits or fewer and places the TMS bit that leaves a shift state in the last position of a chunk, so the engine applies exactly the requested number of cycles and no more. Two read-only headers let a host walking the extended capability list recognise the window. TCK is the system clock divided by a parameter. TMS and TDI change while TCK is low, and TDO is sampled on the TCK rising edge. The bus uses a ready handshake: accesses that would disturb or observe an unfinished shift are held off until it ends.

Top module: `jvs_top`

## Requirements
- R1: A read of offset 0x00 returns the capability header: capability ID 0x000B in bits 15:0, version 1 in bits 19:16, next pointer (parameter, default 0) in bits 31:20.
- R2: A read of offset 0x04 returns the vendor header: ID 0x0008 in bits 15:0, revision 0 in bits 19:16, structure length 0x020 in bits 31:20, i.e. 0x0200_0008.
- R3: Offsets 0x0C (length) and 0x10 (TMS vector) read back the last written 32-bit value. Every offset other than 0x00, 0x04, 0x0C, 0x10 and 0x14 reads zero and ignores writes.
- R4: A write to 0x14 starts a transaction of exactly min(length, 32) TCK pulses. A length of 0 produces no pulse and finishes at once.
- R5: At TCK rising edge i (counting from 0), TMS equals bit i of the TMS vector and TDI equals bit i of the word written to 0x14.
- R6: A read of 0x14 after a transaction returns the TDO level sampled at rising edge i in bit i, and zero in every bit at position min(length, 32) and above.
- R7: While a transaction runs, any write and any read of 0x14 see ready low until it ends. Reads of other offsets complete in the cycle they are presented.
- R8: TCK is low whenever no transaction runs. TMS and TDI keep their last driven values between transactions (zero after reset).
- R9: Each TCK high phase lasts HALF_CYC system clock cycles, so a transaction holds TCK high for min(length, 32) × HALF_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_rd | input | 1 | Read strobe, held until ready |
| bus_wr | input | 1 | Write strobe, held until ready |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while ready is high |
| bus_ready | output | 1 | Access completes in a cycle where this is high |
| jtag_tck | output | 1 | JTAG test clock |
| jtag_tms | output | 1 | JTAG mode select |
| jtag_tdi | output | 1 | JTAG data to the target |
| jtag_tdo | input | 1 | JTAG data from the target |

## Verification
A wrong bit index or an off-by-one end condition shows up at the pins within one transaction. There is then an extra or a missing TCK pulse, a TMS bit shifted by one position against its rising edge, or a captured word whose bits sit one place off or leak above the length. A busy flag that clears too early makes the data read return before the last pulse, and one stuck high stalls the bus forever. The sweep covers every length from 0 to 32 plus clamped lengths, so each position boundary is reached. The headers and the stall behaviour are checked with a shift in flight.

// File: rtl/jvs_pkg.sv
package jvs_pkg;

    localparam int WORD_W   = 32;
    localparam int MAX_BITS = 32;
    localparam int LEN_W    = $clog2(MAX_BITS + 1);
    localparam int IDX_W    = $clog2(MAX_BITS);

    localparam logic [7:0] OFS_CAP = 8'h00;
    localparam logic [7:0] OFS_VSH = 8'h04;
    localparam logic [7:0] OFS_LEN = 8'h0C;
    localparam logic [7:0] OFS_TMS = 8'h10;
    localparam logic [7:0] OFS_DAT = 8'h14;

    localparam logic [15:0] CAP_ID_VENDOR = 16'h000B;
    localparam logic [3:0]  CAP_VERSION   = 4'h1;
    localparam logic [15:0] VSH_ID        = 16'h0008;
    localparam logic [3:0]  VSH_REV       = 4'h0;
    localparam logic [11:0] VSH_LEN       = 12'h020;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_LOW  = 2'd1,
        SH_HIGH = 2'd2
    } sh_state_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] tms;
        logic [WORD_W-1:0] tdi;
    } shift_req_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [WORD_W-1:0] raw);
        if (raw > WORD_W'(MAX_BITS))
            return LEN_W'(MAX_BITS);
        return raw[LEN_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] hdr_word(input logic [11:0] upper,
                                                    input logic [3:0]  ver,
                                                    input logic [15:0] id);
        return {upper, ver, id};
    endfunction

endpackage

// File: rtl/jvs_regs.sv
module jvs_regs
    import jvs_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [11:0] NEXT_PTR = 12'h000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic [WORD_W-1:0] tdo_word,
    output logic [WORD_W-1:0] rdata,
    output logic              ready,
    output logic              start,
    output shift_req_t        req
);
    logic [WORD_W-1:0] len_raw;
    logic [WORD_W-1:0] tms_vec;
    logic              hit_dat;
    logic              stall;
    logic              wr_acc;

    assign hit_dat = (addr == ADDR_W'(OFS_DAT));
    assign stall   = busy && (wr || (rd && hit_dat));
    assign ready   = (rd || wr) && !stall;
    assign wr_acc  = wr && ready;
    assign start   = wr_acc && hit_dat;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_raw <= '0;
            tms_vec <= '0;
        end else if (wr_acc) begin
            if (addr == ADDR_W'(OFS_LEN)) len_raw <= wdata;
            if (addr == ADDR_W'(OFS_TMS)) tms_vec <= wdata;
        end
    end

    always_comb begin
        req.len = clamp_len(len_raw);
        req.tms = tms_vec;
        req.tdi = wdata;
    end

    always_comb begin
        unique case (addr)
            ADDR_W'(OFS_CAP): rdata = hdr_word(NEXT_PTR, CAP_VERSION, CAP_ID_VENDOR);
            ADDR_W'(OFS_VSH): rdata = hdr_word(VSH_LEN, VSH_REV, VSH_ID);
            ADDR_W'(OFS_LEN): rdata = len_raw;
            ADDR_W'(OFS_TMS): rdata = tms_vec;
            ADDR_W'(OFS_DAT): rdata = tdo_word;
            default:          rdata = '0;
        endcase
    end

endmodule

// File: rtl/jvs_tick.sv
module jvs_tick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/jvs_shifter.sv
module jvs_shifter
    import jvs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  shift_req_t        req,
    input  logic              tick,
    input  logic              tdo_in,
    output logic              busy,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic [WORD_W-1:0] tdo_word
);
    sh_state_e         st;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last;
    logic [WORD_W-1:0] tms_sh;
    logic [WORD_W-1:0] tdi_sh;

    assign busy = (st != SH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SH_IDLE;
            idx      <= '0;
            last     <= '0;
            tms_sh   <= '0;
            tdi_sh   <= '0;
            tdo_word <= '0;
            tck      <= 1'b0;
            tms      <= 1'b0;
            tdi      <= 1'b0;
        end else begin
            unique case (st)
                SH_IDLE: begin
                    if (start) begin
                        tdo_word <= '0;
                        if (req.len != '0) begin
                            tms    <= req.tms[0];
                            tdi    <= req.tdi[0];
                            tms_sh <= req.tms >> 1;
                            tdi_sh <= req.tdi >> 1;
                            idx    <= '0;
                            last   <= IDX_W'(req.len - 1'b1);
                            st     <= SH_LOW;
                        end
                    end
                end
                SH_LOW: begin
                    if (tick) begin
                        tck           <= 1'b1;
                        tdo_word[idx] <= tdo_in;
                        st            <= SH_HIGH;
                    end
                end
                SH_HIGH: begin
                    if (tick) begin
                        tck <= 1'b0;
                        if (idx == last) begin
                            st <= SH_IDLE;
                        end else begin
                            idx    <= idx + 1'b1;
                            tms    <= tms_sh[0];
                            tdi    <= tdi_sh[0];
                            tms_sh <= tms_sh >> 1;
                            tdi_sh <= tdi_sh >> 1;
                            st     <= SH_LOW;
                        end
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/jvs_top.sv
module jvs_top
    import jvs_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          HALF_CYC = 4,
    parameter logic [11:0] NEXT_PTR = 12'h000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              jtag_tck,
    output logic              jtag_tms,
    output logic              jtag_tdi,
    input  logic              jtag_tdo
);
    logic              busy;
    logic              start;
    logic              tick;
    shift_req_t        req;
    logic [WORD_W-1:0] tdo_word;

    jvs_regs #(.ADDR_W(ADDR_W), .NEXT_PTR(NEXT_PTR)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .busy     (busy),
        .tdo_word (tdo_word),
        .rdata    (bus_rdata),
        .ready    (bus_ready),
        .start    (start),
        .req      (req)
    );

    jvs_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    jvs_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req      (req),
        .tick     (tick),
        .tdo_in   (jtag_tdo),
        .busy     (busy),
        .tck      (jtag_tck),
        .tms      (jtag_tms),
        .tdi      (jtag_tdi),
        .tdo_word (tdo_word)
    );

endmodule

// File: rtl/jvs_chk.sv
module jvs_chk
    import jvs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              tck,
    input logic              tms,
    input logic              tdi,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic [31:0]       bus_rdata
);
    logic       tck_d;
    logic [6:0] pulses;

    always_ff @(posedge clk) begin
        if (rst) begin
            tck_d  <= 1'b0;
            pulses <= '0;
        end else begin
            tck_d  <= tck;
            if (!busy)
                pulses <= '0;
            else if (tck && !tck_d)
                pulses <= pulses + 1'b1;
        end
    end

    // R4: never more than the maximum number of pulses in one transaction
    a_r4_pulse_bound: assert property (@(posedge clk) disable iff (rst)
        pulses <= 7'(MAX_BITS));

    // R8: TCK low while idle
    a_r8_tck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tck);

    // R8: pins hold between transactions
    a_r8_pins_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> ($stable(tms) && $stable(tdi)));

    // R5: data pins never move while TCK is high
    a_r5_stable_high: assert property (@(posedge clk) disable iff (rst)
        tck |-> ($stable(tms) && $stable(tdi)));

    // R7: data read stalls during a shift
    a_r7_data_stall: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_rd && bus_addr == ADDR_W'(OFS_DAT)) |-> !bus_ready);

    // R7: other reads never stall
    a_r7_other_reads: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr != ADDR_W'(OFS_DAT)) |-> bus_ready);

    // R2: vendor header constant
    a_r2_vendor_hdr: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == ADDR_W'(OFS_VSH)) |-> bus_rdata == 32'h0200_0008);

endmodule

bind jvs_top jvs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .tck       (jtag_tck),
    .tms       (jtag_tms),
    .tdi       (jtag_tdi),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata)
);

// File: tb/tb_jvs_top.sv
`timescale 1ns/1ps
module tb_jvs_top;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        jtag_tck, jtag_tms, jtag_tdi, jtag_tdo;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    logic [6:0]  pcnt = '0;
    logic [63:0] mon_tms = '0;
    logic [63:0] mon_tdi = '0;
    logic [31:0] tdo_pat = '0;
    int          hi_cnt = 0;

    always #2.5 clk = ~clk;

    jvs_top #(.ADDR_W(8), .HALF_CYC(HALF)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .jtag_tck(jtag_tck), .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi), .jtag_tdo(jtag_tdo)
    );

    assign jtag_tdo = (pcnt < 7'd32) ? tdo_pat[pcnt[4:0]] : 1'b0;

    always @(posedge jtag_tck) begin
        if (pcnt < 7'd64) begin
            mon_tms[pcnt[5:0]] = jtag_tms;
            mon_tdi[pcnt[5:0]] = jtag_tdi;
        end
        pcnt = pcnt + 1'b1;
    end

    always @(posedge clk) if (jtag_tck) hi_cnt = hi_cnt + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_xfer(input bit is_wr, input logic [7:0] a, input logic [31:0] d,
                            output logic [31:0] q, output int waits);
        waits = 0;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = is_wr; bus_rd = !is_wr;
        forever begin
            #1;
            if (bus_ready) break;
            waits++;
            @(negedge clk);
        end
        q = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] q; int w;
        bus_xfer(1'b1, a, d, q, w);
    endtask

    task automatic rd32(input logic [7:0] a, output logic [31:0] q);
        int w;
        bus_xfer(1'b0, a, 32'h0, q, w);
    endtask

    task automatic do_shift(input int len, input logic [31:0] tms, input logic [31:0] tdi,
                            input logic [31:0] pat);
        logic [31:0] got, mask;
        int n;
        n = (len > 32) ? 32 : len;
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
        pcnt = '0; mon_tms = '0; mon_tdi = '0; hi_cnt = 0; tdo_pat = pat;
        wr32(8'h0C, 32'(len));
        wr32(8'h10, tms);
        wr32(8'h14, tdi);
        rd32(8'h14, got);
        chk("R4 pulse count", 32'(pcnt), 32'(n));
        chk("R5 tms per edge", mon_tms[31:0] & mask, tms & mask);
        chk("R5 tdi per edge", mon_tdi[31:0] & mask, tdi & mask);
        chk("R6 tdo word", got, pat & mask);
        chk("R9 high time", 32'(hi_cnt), 32'(n * HALF));
        chk("R8 tck idle", 32'(jtag_tck), 32'h0);
        if (n > 0) begin
            chk("R8 tms holds", 32'(jtag_tms), 32'(tms[n-1]));
            chk("R8 tdi holds", 32'(jtag_tdi), 32'(tdi[n-1]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        int w;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state (R8, R3, R6)
        chk("R8 reset tck", 32'(jtag_tck), 32'h0);
        chk("R8 reset tms", 32'(jtag_tms), 32'h0);
        rd32(8'h0C, q); chk("R3 reset len", q, 32'h0);
        rd32(8'h10, q); chk("R3 reset tms", q, 32'h0);
        rd32(8'h14, q); chk("R6 reset tdo", q, 32'h0);

        // headers (R1, R2)
        rd32(8'h00, q); chk("R1 cap header", q, 32'h0001_000B);
        rd32(8'h04, q); chk("R2 vendor header", q, 32'h0200_0008);

        // length sweep (R4, R5, R6, R8, R9)
        for (int len = 0; len <= 33; len++) begin
            logic [31:0] t, d, p;
            t = 32'h9E37_79B9 * 32'(len + 1);
            d = {t[15:0], t[31:16]} ^ 32'h5A5A_A5A5;
            p = (t ^ 32'hC3C3_3C3C) + 32'(len);
            do_shift(len, t, d, p);
        end
        do_shift(40, 32'h8000_0001, 32'hF0F0_0F0F, 32'hDEAD_BEEF);
        do_shift(1, 32'h1, 32'h1, 32'h1);
        do_shift(32, 32'h8000_0000, 32'hAAAA_5555, 32'hFFFF_FFFF);
        // a zero-length transaction after a full one clears the result word (R4, R6)
        do_shift(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // readback and unmapped offsets (R3)
        wr32(8'h0C, 32'h0000_0028);
        wr32(8'h10, 32'h1234_5678);
        rd32(8'h0C, q); chk("R3 len readback", q, 32'h0000_0028);
        rd32(8'h10, q); chk("R3 tms readback", q, 32'h1234_5678);
        wr32(8'h08, 32'hFFFF_FFFF);
        wr32(8'h0D, 32'hFFFF_FFFF);
        rd32(8'h08, q); chk("R3 unmapped 08", q, 32'h0);
        rd32(8'h18, q); chk("R3 unmapped 18", q, 32'h0);
        rd32(8'h0C, q); chk("R3 len untouched", q, 32'h0000_0028);
        rd32(8'h10, q); chk("R3 tms untouched", q, 32'h1234_5678);

        // stall behaviour (R7)
        pcnt = '0; tdo_pat = 32'h0;
        wr32(8'h0C, 32'd32);
        wr32(8'h14, 32'h0);
        bus_xfer(1'b0, 8'h04, 32'h0, q, w);
        chk("R7 header read no wait", 32'(w), 32'h0);
        chk("R2 header during shift", q, 32'h0200_0008);
        bus_xfer(1'b1, 8'h0C, 32'd5, q, w);
        chk("R7 write held to end", 32'(pcnt), 32'd32);
        chk("R7 write waited", 32'(w > 0), 32'h1);
        pcnt = '0;
        wr32(8'h14, 32'h0);
        bus_xfer(1'b0, 8'h14, 32'h0, q, w);
        chk("R7 data read held to end", 32'(pcnt), 32'd5);
        chk("R7 data read waited", 32'(w > 0), 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule